// File: doc/BRIEF.md
# Clock Source Supervisor with Automatic Failover

This block decides which of four candidate clocks should drive a crate-wide clock tree. It runs on a free-running reference clock. For each candidate it receives a toggle signal, a divided-down copy of that clock that flips at a low rate. Each toggle passes through a synchronizer, and its edges are counted against a shared window timer to judge whether the clock is alive. The candidates are a timing-system clock, a front-panel external clock, a stand-alone clock and an internal oscillator clock. The timing-system clock also needs a receiver-ready and a PLL-locked indication before it counts as usable.

Software sets one enable bit per source and a run-mode bit. From these settings and the live presence status, the block picks the active source and drives its code to an external glitch-free clock multiplexer. If the active source dies, the block falls back to the next usable source with no software action. It raises a crate-wide health flag whenever the active source is not the one software asked for. It also keeps a sticky flag that records any change of source.

The window length and the number of good windows needed for recovery are inputs, so software can tune them. A typical setting is 16 reference cycles and 4 windows.

Top module: `clk_source_supervisor`

## Requirements
- R1: While reset is asserted, the outputs take these values: `clk_sel` = 3 (internal), `src_ok` = 0, `failover_flag` = 0 and `crate_ok` = 1.
- R2: A source whose toggle shows no edge during one whole window of `win_len` reference cycles is marked absent at the end of that window. A source whose toggle edges are never more than `win_len - 2` cycles apart stays present.
- R3: An absent source becomes present only at the end of the `rec_windows`-th consecutive window that contains a toggle edge (a value of 0 is treated as 1). Any window without an edge restarts that count.
- R4: `src_ok` bit i reports source i usable, with bit 0 = timing-system, 1 = external, 2 = stand-alone and 3 = internal. Bit 0 is set only while the source is present and both `rx_ready` and `pll_locked` are high.
- R5: `clk_sel` is the lowest-numbered source that is both effectively enabled and usable, using codes 0 = timing-system, 1 = external, 2 = stand-alone and 3 = internal. When no source qualifies, `clk_sel` is 3.
- R6: While `run_mode` is high, the timing-system source counts as enabled and as the requested source, whatever `src_en[0]` holds.
- R7: The requested source is the lowest-numbered effectively enabled source, or 3 if none is enabled. `crate_ok` is high exactly when `clk_sel` equals the requested source.
- R8: `failover_flag` is set on any change of `clk_sel`. It stays set until a `fail_clr` pulse clears it. A source change in the same cycle as `fail_clr` wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_tgl | input | 4 | Toggle signal from each candidate clock (bit order as in R4) |
| rx_ready | input | 1 | Timing receiver ready (asynchronous) |
| pll_locked | input | 1 | Timing PLL locked (asynchronous) |
| src_en | input | 4 | Software enable per source |
| run_mode | input | 1 | Forces the timing-system source to be enabled and requested |
| win_len | input | 8 | Presence window length in reference cycles |
| rec_windows | input | 3 | Consecutive good windows needed for recovery |
| fail_clr | input | 1 | Clears the sticky failover flag |
| clk_sel | output | 2 | Select code for the external clock multiplexer |
| src_ok | output | 4 | Per-source usable status |
| crate_ok | output | 1 | Crate health: high when the active source is the requested one |
| failover_flag | output | 1 | Sticky record of a source change |

## Verification
The bench targets the edge of presence detection in both directions:
- Toggle edges 14 cycles apart must keep a source alive. A design that misjudged its window would drop it.
- Edges 40 cycles apart must leave the source absent. A design that counted windows instead of consecutive windows would slowly bring it back.

Recovery is sampled before the required run of good windows has completed, which catches a design that re-admits a source too early.

The remaining cases cover the selection logic:
- Dropping only the receiver-ready or the PLL-locked indication must push selection off the timing-system source.
- Run mode with no enables must still request that source. When it then dies, the block must fall back to the internal clock with the health flag low.
- The random phases check that the sticky flag follows every change of source and nothing else.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

  localparam int NSRC  = 4;
  localparam int SEL_W = $clog2(NSRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_TIMING     = 2'd0,
    SRC_FRONT      = 2'd1,
    SRC_STANDALONE = 2'd2,
    SRC_INTERNAL   = 2'd3
  } src_e;

  // Lowest set index wins; an empty vector maps to the last (fallback) source.
  function automatic logic [SEL_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [SEL_W-1:0] r;
    r = SEL_W'(NSRC - 1);
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = SEL_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/clksup_sync.sv
module clksup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/clksup_window_timer.sv
module clksup_window_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             tick_o
);

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    // Lengths of 0 and 1 both give a tick every cycle.
    wrap  = (({1'b0, cnt_q} + 1'b1) >= {1'b0, win_len});
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

endmodule

// File: rtl/clksup_presence.sv
module clksup_presence #(
  parameter int REC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl_s,
  input  logic             tick_i,
  input  logic [REC_W-1:0] rec_need,
  output logic             present_o
);

  logic             prev_q, prev_d;
  logic             seen_q, seen_d;
  logic             pres_q, pres_d;
  logic [REC_W-1:0] good_q, good_d;
  logic             edge_w, win_good;
  logic [REC_W-1:0] need;

  always_comb begin
    edge_w   = tgl_s ^ prev_q;
    win_good = seen_q | edge_w;
    need     = (rec_need == '0) ? REC_W'(1) : rec_need;
    prev_d   = tgl_s;
    seen_d   = tick_i ? 1'b0 : win_good;
    pres_d   = pres_q;
    good_d   = good_q;
    if (tick_i) begin
      if (!win_good) begin
        pres_d = 1'b0;
        good_d = '0;
      end else if (!pres_q) begin
        if (({1'b0, good_q} + 1'b1) >= {1'b0, need}) begin
          pres_d = 1'b1;
          good_d = '0;
        end else begin
          good_d = good_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      pres_q <= 1'b0;
      good_q <= '0;
    end else begin
      prev_q <= prev_d;
      seen_q <= seen_d;
      pres_q <= pres_d;
      good_q <= good_d;
    end
  end

  assign present_o = pres_q;

  AST_LOSS_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pres_q) |-> $past(tick_i)); // R2
  AST_RECOVER_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres_q) |-> ($past(tick_i) && $past(seen_q | edge_w))); // R3

endmodule

// File: rtl/clksup_select.sv
module clksup_select
  import clksup_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  usable,
  input  logic [NSRC-1:0]  src_en,
  input  logic             run_mode,
  input  logic             fail_clr,
  output logic [SEL_W-1:0] sel_o,
  output logic             health_o,
  output logic             flag_o
);

  logic [NSRC-1:0]  en_eff, qual;
  logic [SEL_W-1:0] sel_q, sel_d, req_q, req_d;
  logic             health_q, health_d;
  logic             flag_q, flag_d;

  always_comb begin
    en_eff    = src_en;
    en_eff[0] = src_en[0] | run_mode;
    qual      = en_eff & usable;
    sel_d     = first_set(qual);
    req_d     = first_set(en_eff);
    health_d  = (sel_d == req_d);
    flag_d    = (sel_d != sel_q) | (flag_q & ~fail_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SRC_INTERNAL;
      req_q    <= SRC_INTERNAL;
      health_q <= 1'b1;
      flag_q   <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      req_q    <= req_d;
      health_q <= health_d;
      flag_q   <= flag_d;
    end
  end

  assign sel_o    = sel_q;
  assign health_o = health_q;
  assign flag_o   = flag_q;

  AST_TIMING_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    qual[0] |=> (sel_q == SRC_TIMING)); // R5
  AST_FALLBACK_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == '0) |=> (sel_q == SRC_INTERNAL)); // R5
  AST_RUN_REQUESTS_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    run_mode |=> (req_q == SRC_TIMING)); // R6
  AST_HEALTH_LOW_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && !usable[0]) |=> !health_q); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) && !$past(fail_clr)) |-> flag_q); // R8
  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> flag_q); // R8

endmodule

// File: rtl/clk_source_supervisor.sv
module clk_source_supervisor
  import clksup_pkg::*;
#(
  parameter int WIN_W       = 8,
  parameter int REC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tgl,
  input  logic             rx_ready,
  input  logic             pll_locked,
  input  logic [NSRC-1:0]  src_en,
  input  logic             run_mode,
  input  logic [WIN_W-1:0] win_len,
  input  logic [REC_W-1:0] rec_windows,
  input  logic             fail_clr,
  output logic [SEL_W-1:0] clk_sel,
  output logic [NSRC-1:0]  src_ok,
  output logic             crate_ok,
  output logic             failover_flag
);

  localparam int SYNC_W = NSRC + 2;

  logic [SYNC_W-1:0] async_in, sync_out;
  logic [NSRC-1:0]   tgl_s, present, usable;
  logic              rdy_s, lock_s, tick;

  assign async_in = {pll_locked, rx_ready, src_tgl};

  clksup_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (async_in),
    .q     (sync_out)
  );

  assign tgl_s  = sync_out[NSRC-1:0];
  assign rdy_s  = sync_out[NSRC];
  assign lock_s = sync_out[NSRC+1];

  clksup_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .win_len (win_len),
    .tick_o  (tick)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_det
    clksup_presence #(.REC_W(REC_W)) u_det (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .tgl_s     (tgl_s[g]),
      .tick_i    (tick),
      .rec_need  (rec_windows),
      .present_o (present[g])
    );
  end

  always_comb begin
    usable    = present;
    usable[0] = present[0] & rdy_s & lock_s;
  end

  clksup_select u_select (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .usable   (usable),
    .src_en   (src_en),
    .run_mode (run_mode),
    .fail_clr (fail_clr),
    .sel_o    (clk_sel),
    .health_o (crate_ok),
    .flag_o   (failover_flag)
  );

  assign src_ok = usable;

  AST_TIMING_NEEDS_READY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (clk_sel == SRC_TIMING) |-> $past(rdy_s && lock_s)); // R4

endmodule

// File: tb/tb_clk_source_supervisor.sv
module tb_clk_source_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 16;
  localparam int REC        = 4;
  localparam int SETTLE     = (REC + 3) * WIN + 10;

  logic       ref_clk;
  logic       rst_n;
  logic [3:0] src_tgl;
  logic       rx_ready, pll_locked;
  logic [3:0] src_en;
  logic       run_mode;
  logic [7:0] win_len;
  logic [2:0] rec_windows;
  logic       fail_clr;
  logic [1:0] clk_sel;
  logic [3:0] src_ok;
  logic       crate_ok, failover_flag;

  int  checks = 0;
  int  errors = 0;
  int  per [4];
  int  cnt [4];
  logic [3:0] alive;
  int  last_sel;

  clk_source_supervisor dut (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .src_tgl       (src_tgl),
    .rx_ready      (rx_ready),
    .pll_locked    (pll_locked),
    .src_en        (src_en),
    .run_mode      (run_mode),
    .win_len       (win_len),
    .rec_windows   (rec_windows),
    .fail_clr      (fail_clr),
    .clk_sel       (clk_sel),
    .src_ok        (src_ok),
    .crate_ok      (crate_ok),
    .failover_flag (failover_flag)
  );

  initial begin
    ref_clk = 1'b0;
    forever #(CLK_PERIOD / 2) ref_clk = ~ref_clk;
  end

  // Toggle generators: per[i] = cycles between toggle edges, 0 = stopped.
  initial begin
    src_tgl = '0;
    for (int i = 0; i < 4; i++) begin per[i] = 0; cnt[i] = 0; end
    forever begin
      @(negedge ref_clk);
      for (int i = 0; i < 4; i++) begin
        if (per[i] != 0) begin
          if (cnt[i] + 1 >= per[i]) begin
            src_tgl[i] = ~src_tgl[i];
            cnt[i] = 0;
          end else begin
            cnt[i] = cnt[i] + 1;
          end
        end
      end
    end
  end

  function automatic int low_set(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 3;
  endfunction

  function automatic logic [3:0] exp_usable();
    logic [3:0] u;
    u = alive;
    u[0] = alive[0] & rx_ready & pll_locked;
    return u;
  endfunction

  function automatic logic [3:0] exp_en_eff();
    logic [3:0] e;
    e = src_en;
    e[0] = src_en[0] | run_mode;
    return e;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic set_src(input int i, input int p);
    per[i] = p;
    alive[i] = (p != 0) && (p <= WIN - 2);
  endtask

  task automatic settle_check(input string tag, input int n);
    int es, er;
    cycles(n);
    es = low_set(exp_en_eff() & exp_usable());
    er = low_set(exp_en_eff());
    check({tag, " R4 src_ok"}, int'(src_ok), int'(exp_usable()));
    check({tag, " R5 clk_sel"}, int'(clk_sel), es);
    check({tag, " R7 crate_ok"}, int'(crate_ok), int'(es == er));
    check({tag, " R8 flag set"}, int'(failover_flag), int'(es != last_sel));
    fail_clr = 1'b1;
    cycles(1);
    fail_clr = 1'b0;
    cycles(1);
    check({tag, " R8 flag cleared"}, int'(failover_flag), 0);
    last_sel = es;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    rx_ready    = 1'b1;
    pll_locked  = 1'b1;
    src_en      = 4'b0000;
    run_mode    = 1'b0;
    win_len     = 8'(WIN);
    rec_windows = 3'(REC);
    fail_clr    = 1'b0;
    alive       = '0;
    last_sel    = 3;
    void'($urandom(32'd20240917));

    cycles(4);
    check("R1 reset clk_sel", int'(clk_sel), 3);
    check("R1 reset src_ok", int'(src_ok), 0);
    check("R1 reset flag", int'(failover_flag), 0);
    check("R1 reset crate_ok", int'(crate_ok), 1);
    rst_n = 1'b1;

    // All sources alive and enabled: timing source wins.
    for (int i = 0; i < 4; i++) set_src(i, 3 + i);
    src_en = 4'b1111;
    settle_check("all alive", SETTLE);

    // R4: each readiness input alone disqualifies the timing source.
    rx_ready = 1'b0;
    settle_check("R4 not ready", 10);
    rx_ready = 1'b1; pll_locked = 1'b0;
    settle_check("R4 not locked", 10);
    pll_locked = 1'b1;
    settle_check("R4 restored", 10);

    // R2/R3: loss of timing toggle, then early and full recovery.
    set_src(0, 0);
    settle_check("R2 timing lost", 3 * WIN + 8);
    set_src(0, 3);
    cycles((REC - 1) * WIN - 4);
    check("R3 early recovery src_ok0", int'(src_ok[0]), 0);
    check("R3 early recovery clk_sel", int'(clk_sel), 1);
    settle_check("R3 recovered", 3 * WIN);

    // R2: edge spacing just inside the window keeps presence.
    set_src(0, WIN - 2);
    settle_check("R2 slow inside window", 10 * WIN);
    per[0] = 40; alive[0] = 1'b0;
    settle_check("R2 too slow", 10 * WIN);
    set_src(0, 3);
    settle_check("R2 fast again", SETTLE);

    // R6: run mode with no enables requests the timing source.
    src_en = 4'b0000; run_mode = 1'b1;
    settle_check("R6 run mode", 10);
    set_src(0, 0);
    settle_check("R6 run mode fallback internal", SETTLE);
    run_mode = 1'b0;
    settle_check("R7 nothing enabled", 10);

    // R8: flag stays set with no clear.
    set_src(0, 3);
    src_en = 4'b0001;
    cycles(SETTLE);
    cycles(50);
    check("R8 sticky hold", int'(failover_flag), 1);
    check("R5 timing selected", int'(clk_sel), 0);
    fail_clr = 1'b1; cycles(1); fail_clr = 1'b0; cycles(1);
    check("R8 clear", int'(failover_flag), 0);
    last_sel = 0;

    // Random phases: presence changes, then configuration changes.
    for (int it = 0; it < 14; it++) begin
      for (int i = 0; i < 4; i++) begin
        if (($urandom % 3) != 0) set_src(i, 2 + int'($urandom % 11));
        else                     set_src(i, 0);
      end
      rx_ready   = (($urandom % 4) != 0);
      pll_locked = (($urandom % 4) != 0);
      settle_check("rand presence R2 R3", SETTLE);
      src_en   = 4'($urandom);
      run_mode = (($urandom % 4) == 0);
      settle_check("rand config R5 R6 R7", 6);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule